// File: doc/BRIEF.md
# Address-Translation Configuration Register Bank

This block holds the software-visible configuration and fault-reporting state of an I/O address-translation unit. Software reaches it through a simple word-addressed register port: a read or a write is one request cycle, writes take effect at the clock edge, and read data comes back one cycle later. Every register has its own write mask. Some bits are forced to one and cannot be cleared. The mask-ID register can only gain set bits.

The bank also feeds the translator. It presents the enable bit and the page-table base. It turns the 3-bit range field of the control word into the base address of the translation window. The window covers the top of the 32-bit space, from 16 MB up to 2 GB. When the translator hits a fault, it loads the fault status and fault address through a capture port in one cycle, and that raises a fault interrupt. Any software access to either fault register lowers the interrupt again. Neither the register port nor the capture port has back-pressure: both are always accepted, so no ready signal exists, and a request is taken on every cycle its select or valid is high.

Top module: `xlat_cfg_regs`

## Requirements
- R1: After reset these registers read as follows: control reads the version value (default 0x41000000), fault status 0x00800000, arbiter enable 0x00000003, arbitration enable 0x00000008 and mask ID 0x23000000. All other registers read 0. Also after reset, `win_base` is 0 and `fault_irq` is low.
- R2: A write to control (word 0x000) keeps only the data bits under 0x0000001D and ORs the version value into them. `xlat_en` follows bit 0 of control.
- R3: A control write sets `win_base` to 2^32 minus (16 MB shifted left by the range code), where the range code is data bits 4:2. Code 0 gives 0xFF000000 and code 7 gives 0x80000000. The new value shows in the cycle after the write, and `win_base` changes at no other time.
- R4: A write to the base register (word 0x001) is masked with 0x07FFFC00, and `pt_base` shows the stored value. The full-flush register (word 0x005) and the page-flush register (word 0x006) store all 32 bits.
- R5: A write to arbiter enable (word 0x402) is masked with 0x801F000F, and bit 0 always reads as 1.
- R6: A write to fault status (word 0x400) is masked with 0xFF0FFFFF, and bit 23 is forced to 1. A write to fault address (word 0x401) stores all 32 bits.
- R7: The four slot-configuration registers (words 0x404 to 0x407) are each masked with 0x00010003 and are independent of one another. A write to arbitration enable (word 0x800) is masked with 0x001F0000, and bit 3 is forced to 1.
- R8: A write to mask ID (word 0xC06) ORs data bits 23:0 into the stored value. No write ever clears a bit of mask ID.
- R9: A cycle with `flt_valid` high loads fault status with (`flt_status` & 0xFF0FFFFF) | 0x00800000 and loads fault address with `flt_addr`. `fault_irq` is high in the following cycle.
- R10: When no capture happens in the same cycle, any read or write of fault status or fault address makes `fault_irq` low in the following cycle.
- R11: When a capture and a software access to a fault register happen in the same cycle, the capture wins. The registers take the captured values, and `fault_irq` is high in the following cycle.
- R12: A read of any unmapped word returns 0. A write to an unmapped word changes no register.
- R13: Every read request gives `bus_rvalid` high, with its data, in exactly the next cycle. `bus_rvalid` is low after every cycle that has no read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| flt_valid | input | 1 | Fault capture strobe from the translator |
| flt_status | input | 32 | Fault status to capture |
| flt_addr | input | 32 | Faulting address to capture |
| fault_irq | output | 1 | Fault interrupt |
| xlat_en | output | 1 | Translation enable (control bit 0) |
| win_base | output | 32 | Translation window base address |
| pt_base | output | 32 | Page-table base register value |

## Verification
Every result of this block is due exactly one cycle after the cycle that causes it. Read data and `bus_rvalid` follow the read request, a new `win_base` follows the control write, and a change of `fault_irq` follows the capture or the fault-register access. The bench drives each request for one full cycle. Its reference model advances once per clock edge with the inputs that were held at that edge, and the design's outputs are compared with the model at the falling edge that follows. A result that comes one cycle early or late therefore shows up as a mismatch. Same-cycle capture-versus-access collisions and reads of unmapped words get their own targeted checks.

// File: rtl/xlat_cfg_pkg.sv
package xlat_cfg_pkg;
  localparam int DW = 32;

  // word offsets (byte offset >> 2)
  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_BASE   = 12'h001;
  localparam logic [11:0] OFS_FLUSH  = 12'h005;
  localparam logic [11:0] OFS_PGFL   = 12'h006;
  localparam logic [11:0] OFS_FSR    = 12'h400;
  localparam logic [11:0] OFS_FAR    = 12'h401;
  localparam logic [11:0] OFS_AER    = 12'h402;
  localparam logic [11:0] OFS_SLOT0  = 12'h404;
  localparam logic [11:0] OFS_ARBEN  = 12'h800;
  localparam logic [11:0] OFS_MID    = 12'hC06;

  // write masks and forced-one bits
  localparam logic [DW-1:0] M_CTRL  = 32'h0000_001D;
  localparam logic [DW-1:0] M_BASE  = 32'h07FF_FC00;
  localparam logic [DW-1:0] M_FSR   = 32'hFF0F_FFFF;
  localparam logic [DW-1:0] F_FSR   = 32'h0080_0000;
  localparam logic [DW-1:0] M_AER   = 32'h801F_000F;
  localparam logic [DW-1:0] F_AER   = 32'h0000_0001;
  localparam logic [DW-1:0] M_SLOT  = 32'h0001_0003;
  localparam logic [DW-1:0] M_ARBEN = 32'h001F_0000;
  localparam logic [DW-1:0] F_ARBEN = 32'h0000_0008;
  localparam logic [DW-1:0] M_MID   = 32'h00FF_FFFF;

  // reset values
  localparam logic [DW-1:0] RV_AER = 32'h0000_0003;
  localparam logic [DW-1:0] RV_MID = 32'h2300_0000;

  localparam logic [63:0] WIN_UNIT = 64'h0000_0000_0100_0000;  // 16 MB
  localparam logic [63:0] SPACE_TOP = 64'h0000_0001_0000_0000;

  function automatic logic [DW-1:0] range_to_base(input logic [2:0] code);
    logic [63:0] span;
    logic [63:0] diff;
    span = WIN_UNIT << code;
    diff = SPACE_TOP - span;
    return diff[DW-1:0];
  endfunction
endpackage

// File: rtl/xlat_win_decode.sv
module xlat_win_decode
  import xlat_cfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [2:0]    code,
  output logic [DW-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst)       base <= '0;
    else if (load) base <= range_to_base(code);
  end
endmodule

// File: rtl/xlat_fault_irq.sv
module xlat_fault_irq (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic sw_touch,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)           irq <= 1'b0;
    else if (capture)  irq <= 1'b1;   // capture has priority
    else if (sw_touch) irq <= 1'b0;
  end
endmodule

// File: rtl/xlat_slot_cfg.sv
module xlat_slot_cfg #(
  parameter int          W    = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & MASK;
  end
endmodule

// File: rtl/xlat_cfg_regs.sv
module xlat_cfg_regs
  import xlat_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] VERSION   = 32'h4100_0000,
  parameter int          NUM_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_rvalid,
  output logic [31:0]       bus_rdata,
  input  logic              flt_valid,
  input  logic [31:0]       flt_status,
  input  logic [31:0]       flt_addr,
  output logic              fault_irq,
  output logic              xlat_en,
  output logic [31:0]       win_base,
  output logic [31:0]       pt_base
);
  logic wr, rd;
  logic hit_ctrl, hit_base, hit_flush, hit_pgfl, hit_fsr, hit_far;
  logic hit_aer, hit_arben, hit_mid;

  logic [DW-1:0] ctrl_q, base_q, flush_q, pgfl_q, fsr_q, far_q;
  logic [DW-1:0] aer_q, arben_q, mid_q;
  logic [DW-1:0] slot_q [NUM_SLOTS];
  logic [DW-1:0] rd_mux;

  assign wr = bus_sel &  bus_we;
  assign rd = bus_sel & ~bus_we;

  assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_base  = (bus_addr == ADDR_W'(OFS_BASE));
  assign hit_flush = (bus_addr == ADDR_W'(OFS_FLUSH));
  assign hit_pgfl  = (bus_addr == ADDR_W'(OFS_PGFL));
  assign hit_fsr   = (bus_addr == ADDR_W'(OFS_FSR));
  assign hit_far   = (bus_addr == ADDR_W'(OFS_FAR));
  assign hit_aer   = (bus_addr == ADDR_W'(OFS_AER));
  assign hit_arben = (bus_addr == ADDR_W'(OFS_ARBEN));
  assign hit_mid   = (bus_addr == ADDR_W'(OFS_MID));

  // plain registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= VERSION;
      base_q  <= '0;
      flush_q <= '0;
      pgfl_q  <= '0;
      aer_q   <= RV_AER;
      arben_q <= F_ARBEN;
      mid_q   <= RV_MID;
    end else if (wr) begin
      if (hit_ctrl)  ctrl_q  <= (bus_wdata & M_CTRL) | VERSION;
      if (hit_base)  base_q  <= bus_wdata & M_BASE;
      if (hit_flush) flush_q <= bus_wdata;
      if (hit_pgfl)  pgfl_q  <= bus_wdata;
      if (hit_aer)   aer_q   <= (bus_wdata & M_AER) | F_AER;
      if (hit_arben) arben_q <= (bus_wdata & M_ARBEN) | F_ARBEN;
      if (hit_mid)   mid_q   <= mid_q | (bus_wdata & M_MID);
    end
  end

  // fault registers: capture beats software write
  always_ff @(posedge clk) begin
    if (rst) begin
      fsr_q <= F_FSR;
      far_q <= '0;
    end else if (flt_valid) begin
      fsr_q <= (flt_status & M_FSR) | F_FSR;
      far_q <= flt_addr;
    end else if (wr) begin
      if (hit_fsr) fsr_q <= (bus_wdata & M_FSR) | F_FSR;
      if (hit_far) far_q <= bus_wdata;
    end
  end

  // per-slot configuration
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    xlat_slot_cfg #(.W(DW), .MASK(M_SLOT)) i_slot (
      .clk   (clk),
      .rst   (rst),
      .we    (wr && (bus_addr == ADDR_W'(OFS_SLOT0 + 12'(g)))),
      .wdata (bus_wdata),
      .q     (slot_q[g])
    );
  end

  xlat_win_decode i_win (
    .clk  (clk),
    .rst  (rst),
    .load (wr && hit_ctrl),
    .code (bus_wdata[4:2]),
    .base (win_base)
  );

  xlat_fault_irq i_irq (
    .clk      (clk),
    .rst      (rst),
    .capture  (flt_valid),
    .sw_touch (bus_sel && (hit_fsr || hit_far)),
    .irq      (fault_irq)
  );

  // read mux
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)  rd_mux = ctrl_q;
    if (hit_base)  rd_mux = base_q;
    if (hit_flush) rd_mux = flush_q;
    if (hit_pgfl)  rd_mux = pgfl_q;
    if (hit_fsr)   rd_mux = fsr_q;
    if (hit_far)   rd_mux = far_q;
    if (hit_aer)   rd_mux = aer_q;
    if (hit_arben) rd_mux = arben_q;
    if (hit_mid)   rd_mux = mid_q;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (bus_addr == ADDR_W'(OFS_SLOT0 + 12'(i))) rd_mux = slot_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end

  assign xlat_en = ctrl_q[0];
  assign pt_base = base_q;
endmodule

// File: rtl/xlat_cfg_chk.sv
module xlat_cfg_chk
  import xlat_cfg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic [31:0]       bus_rdata,
  input logic              flt_valid,
  input logic [31:0]       flt_status,
  input logic [31:0]       flt_addr,
  input logic              fault_irq,
  input logic              xlat_en,
  input logic [31:0]       win_base,
  input logic [31:0]       pt_base
);
  p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
    flt_valid |=> fault_irq);

  p_irq_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !flt_valid &&
     (bus_addr == ADDR_W'(OFS_FSR) || bus_addr == ADDR_W'(OFS_FAR))) |=> !fault_irq);

  p_rd_resp_r13: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we) |=> bus_rvalid);

  p_rd_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_we) |=> !bus_rvalid);

  p_win_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_we && bus_addr == ADDR_W'(OFS_CTRL)) |=> $stable(win_base));

  p_aer_force_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == ADDR_W'(OFS_AER)) |-> bus_rdata[0]);

  p_arben_force_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == ADDR_W'(OFS_ARBEN)) |-> bus_rdata[3]);

  p_ctrl_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == ADDR_W'(OFS_CTRL)) |-> ((bus_rdata & 32'h00FF_FFE2) == 32'h0));
endmodule

bind xlat_cfg_regs xlat_cfg_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_xlat_cfg_regs.sv
module test_xlat_cfg_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] VER = 32'h4100_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        flt_valid = 1'b0;
  logic [31:0] flt_status = '0, flt_addr = '0;
  logic        fault_irq, xlat_en;
  logic [31:0] win_base, pt_base;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_cfg_regs i_xlat_cfg_regs (.*);

  // reference model state
  logic [31:0] mreg [int];
  logic        m_rvalid;
  logic [31:0] m_rdata;
  logic        m_irq;
  logic [31:0] m_win;

  function automatic bit mapped(input int a);
    return a == 'h000 || a == 'h001 || a == 'h005 || a == 'h006 ||
           a == 'h400 || a == 'h401 || a == 'h402 ||
           (a >= 'h404 && a <= 'h407) || a == 'h800 || a == 'hC06;
  endfunction

  task automatic model_reset();
    mreg.delete();
    mreg['h000] = VER;         mreg['h001] = 0; mreg['h005] = 0; mreg['h006] = 0;
    mreg['h400] = 32'h0080_0000; mreg['h401] = 0; mreg['h402] = 32'h3;
    for (int i = 'h404; i <= 'h407; i++) mreg[i] = 0;
    mreg['h800] = 32'h8; mreg['hC06] = 32'h2300_0000;
    m_rvalid = 0; m_rdata = 0; m_irq = 0; m_win = 0;
  endtask

  task automatic model_step();
    int a;
    longint span;
    a = int'(bus_addr);
    m_rvalid = bus_sel && !bus_we;
    if (m_rvalid) m_rdata = mapped(a) ? mreg[a] : 32'h0;
    if (bus_sel && bus_we && mapped(a)) begin
      case (a)
        'h000: begin
          mreg[a] = (bus_wdata & 32'h1D) | VER;
          span = longint'(16) * 1024 * 1024 * (longint'(1) << bus_wdata[4:2]);
          m_win = 32'(longint'(64'h1_0000_0000) - span);
        end
        'h001: mreg[a] = bus_wdata & 32'h07FF_FC00;
        'h400: mreg[a] = (bus_wdata & 32'hFF0F_FFFF) | 32'h0080_0000;
        'h402: mreg[a] = (bus_wdata & 32'h801F_000F) | 32'h1;
        'h800: mreg[a] = (bus_wdata & 32'h001F_0000) | 32'h8;
        'hC06: mreg[a] = mreg[a] | (bus_wdata & 32'h00FF_FFFF);
        'h404, 'h405, 'h406, 'h407: mreg[a] = bus_wdata & 32'h0001_0003;
        default: mreg[a] = bus_wdata;
      endcase
    end
    if (flt_valid) begin
      mreg['h400] = (flt_status & 32'hFF0F_FFFF) | 32'h0080_0000;
      mreg['h401] = flt_addr;
      m_irq = 1;
    end else if (bus_sel && (a == 'h400 || a == 'h401)) begin
      m_irq = 0;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R13", 32'(bus_rvalid), 32'(m_rvalid));
    if (m_rvalid) chk(cur_req, bus_rdata, m_rdata);
    chk(cur_req, 32'(fault_irq), 32'(m_irq));
    chk("R3", win_base, m_win);
    chk("R2", 32'(xlat_en), 32'(mreg['h000][0]));
    chk("R4", pt_base, mreg['h001]);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    model_step();
    compare_all();
    bus_sel = 0; bus_we = 0; flt_valid = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = 12'(a); bus_wdata = d; step();
  endtask

  task automatic rd(input int a);
    bus_sel = 1; bus_we = 0; bus_addr = 12'(a); step();
  endtask

  task automatic capture(input logic [31:0] st, input logic [31:0] ad);
    flt_valid = 1; flt_status = st; flt_addr = ad;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset values of every register
    cur_req = "R1";
    chk("R1", win_base, 32'h0);
    chk("R1", 32'(fault_irq), 32'h0);
    foreach (mreg[k]) rd(k);
    rd('h400); chk("R1", bus_rdata, 32'h0080_0000);
    rd('hC06); chk("R1", bus_rdata, 32'h2300_0000);

    // R2: control mask and version
    cur_req = "R2";
    wr('h000, 32'hFFFF_FFFF); rd('h000);
    chk("R2", bus_rdata, 32'h4100_001D);
    chk("R2", 32'(xlat_en), 32'h1);
    wr('h000, 32'h0000_0002); rd('h000);
    chk("R2", bus_rdata, VER);

    // R3: every range code
    cur_req = "R3";
    for (int c = 0; c < 8; c++) begin
      wr('h000, 32'(c << 2) | 32'h1);
      if (c == 0) chk("R3", win_base, 32'hFF00_0000);
      if (c == 7) chk("R3", win_base, 32'h8000_0000);
      rd('h000);
    end
    wr('h001, 32'h1234_5678); // not control: window must hold
    chk("R3", win_base, 32'h8000_0000);

    // R4: base and flush registers
    cur_req = "R4";
    wr('h001, 32'hFFFF_FFFF); rd('h001);
    chk("R4", bus_rdata, 32'h07FF_FC00);
    wr('h005, 32'hDEAD_BEEF); rd('h005);
    wr('h006, 32'hCAFE_F00D); rd('h006);
    chk("R4", bus_rdata, 32'hCAFE_F00D);

    // R5: arbiter enable
    cur_req = "R5";
    wr('h402, 32'h0); rd('h402); chk("R5", bus_rdata, 32'h1);
    wr('h402, 32'hFFFF_FFFF); rd('h402); chk("R5", bus_rdata, 32'h801F_000F);

    // R6: fault status / address writes
    cur_req = "R6";
    wr('h400, 32'h0); rd('h400); chk("R6", bus_rdata, 32'h0080_0000);
    wr('h400, 32'hFFFF_FFFF); rd('h400); chk("R6", bus_rdata, 32'hFF8F_FFFF);
    wr('h401, 32'h8765_4321); rd('h401); chk("R6", bus_rdata, 32'h8765_4321);

    // R7: slots and arbitration enable
    cur_req = "R7";
    for (int s = 0; s < 4; s++) wr('h404 + s, 32'hFFFF_FFF0 | 32'(s));
    for (int s = 0; s < 4; s++) rd('h404 + s);
    rd('h407); chk("R7", bus_rdata, 32'h0001_0003);
    rd('h404); chk("R7", bus_rdata, 32'h0001_0000);
    wr('h800, 32'h0); rd('h800); chk("R7", bus_rdata, 32'h8);
    wr('h800, 32'hFFFF_FFFF); rd('h800); chk("R7", bus_rdata, 32'h001F_0008);

    // R8: mask ID only gains bits
    cur_req = "R8";
    wr('hC06, 32'hFF00_00F0); wr('hC06, 32'h0000_000F); wr('hC06, 32'h0);
    rd('hC06); chk("R8", bus_rdata, 32'h2300_00FF);

    // R9: capture raises interrupt
    cur_req = "R9";
    capture(32'hFFFF_FFFF, 32'hF000_1000); step();
    chk("R9", 32'(fault_irq), 32'h1);
    cur_req = "R10";
    rd('h400); chk("R9", bus_rdata, 32'hFF8F_FFFF);
    // R10: that read cleared it
    chk("R10", 32'(fault_irq), 32'h0);
    cur_req = "R9";
    capture(32'h4000_0000, 32'h1111_2000); step();
    cur_req = "R10";
    wr('h401, 32'h5); chk("R10", 32'(fault_irq), 32'h0);
    cur_req = "R9";
    capture(32'h0, 32'h2222_3000); step();
    cur_req = "R10";
    rd('h401); chk("R10", bus_rdata, 32'h2222_3000);
    chk("R10", 32'(fault_irq), 32'h0);

    // R11: capture beats same-cycle access
    cur_req = "R11";
    bus_sel = 1; bus_we = 1; bus_addr = 12'h400; bus_wdata = 32'h0;
    capture(32'h2000_0000, 32'hABCD_E000); step();
    chk("R11", 32'(fault_irq), 32'h1);
    bus_sel = 1; bus_we = 0; bus_addr = 12'h401;
    capture(32'h1000_0000, 32'h0BAD_0000); step();
    chk("R11", 32'(fault_irq), 32'h1);
    chk("R11", bus_rdata, 32'hABCD_E000);
    rd('h400); chk("R11", bus_rdata, 32'h1080_0000);

    // R12: unmapped words
    cur_req = "R12";
    rd('h003); chk("R12", bus_rdata, 32'h0);
    wr('h003, 32'hFFFF_FFFF); rd('h003); chk("R12", bus_rdata, 32'h0);
    wr('h408, 32'hFFFF_FFFF); wr('h002, 32'hFFFF_FFFF);
    foreach (mreg[k]) rd(k);

    // R13: idle cycles give no read valid
    cur_req = "R13";
    step(); step();
    chk("R13", 32'(bus_rvalid), 32'h0);

    finish_run();
  end
endmodule